// File: doc/BRIEF.md
# Push-Button LED Position Stepper

This block drives a bar of LEDs with exactly one lamp lit and moves that lamp one place per button press. One button steps the light toward the most significant LED, the other toward the least significant one. The reset button returns the light to a fixed position off the centre of the bar. All three buttons are active low and asynchronous to the system clock.

Each button input passes through a two-stage synchronizer. A press is detected as a high-to-low change between two consecutive synchronized samples. That detection gives a pulse one cycle long, so holding a button down gives exactly one step. The next LED pattern is computed combinationally from the registered pattern and loaded on the clock edge. The whole block runs in a single clock domain. Debouncing is not part of the block: the inputs are assumed to be clean levels.

Top module: `led_bar_stepper`

## Requirements
- R1: The LED output always has exactly one bit set, except in the time before the first reset.
- R2: After the reset button has been low across a rising edge, the LED output reads 8'h10 (bit 4 lit) from the third rising edge on. It stays at that value while reset is held.
- R3: A press of the down button moves the lit bit one position toward bit 7 (a left shift).
- R4: A press of the up button moves the lit bit one position toward bit 0 (a right shift).
- R5: If both buttons are pressed in the same cycle, the pattern is unchanged.
- R6: At bit 7 a down press leaves the pattern unchanged. At bit 0 an up press leaves the pattern unchanged.
- R7: A button held low for any number of cycles produces only one step.
- R8: A step appears on the LED output at the third rising edge after the button input falls. The output is unchanged after the second rising edge.
- R9: Releasing a button (a low-to-high change) does not move the light.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_btn_n | input | 1 | Reset button, active low, asynchronous |
| btn_up_n | input | 1 | Step toward bit 0, active low, asynchronous |
| btn_down_n | input | 1 | Step toward bit 7, active low, asynchronous |
| led | output | 8 | Registered one-hot LED pattern |

## Verification
If the position register enters a wrong state, the LED output shows it immediately and permanently. A pattern with zero or two lit bits, or a lamp in the wrong place, cannot correct itself, because every later step starts from the wrong value. A fault in the edge detector shows up within three cycles of a press: a held button steps more than once, a release causes a step, or a step is lost. A fault in the synchronizer depth shows up as a step one cycle early or late, so the bench samples the output both just before and just after the expected edge.

// File: rtl/led_step_pkg.sv
package led_step_pkg;

  typedef enum logic [1:0] {
    MV_HOLD  = 2'd0,
    MV_LEFT  = 2'd1,
    MV_RIGHT = 2'd2
  } move_e;

  // One step per cycle; simultaneous requests cancel.
  function automatic move_e decode_move(input logic go_left, input logic go_right);
    if (go_left && !go_right)
      return MV_LEFT;
    else if (go_right && !go_left)
      return MV_RIGHT;
    else
      return MV_HOLD;
  endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    chain[0] <= async_in;
    for (int s = 1; s < STAGES; s++) begin
      chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/fall_detect.sv
module fall_detect #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic [W-1:0] level,
  output logic [W-1:0] fall
);

  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    prev <= level;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      assign fall[g] = prev[g] & ~level[g];
    end
  endgenerate

endmodule

// File: rtl/led_track.sv
module led_track
  import led_step_pkg::*;
#(
  parameter int W         = 8,
  parameter int START_POS = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go_left,
  input  logic         go_right,
  output logic [W-1:0] led
);

  localparam logic [W-1:0] START_PAT = W'(1) << START_POS;

  move_e        mv;
  logic [W-1:0] nxt;

  always_comb begin
    mv  = decode_move(go_left, go_right);
    nxt = led;
    unique case (mv)
      MV_LEFT:  if (!led[W-1]) nxt = led << 1;
      MV_RIGHT: if (!led[0])   nxt = led >> 1;
      default:  nxt = led;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) led <= START_PAT;
    else     led <= nxt;
  end

endmodule

// File: rtl/led_bar_stepper.sv
module led_bar_stepper #(
  parameter int LED_W       = 8,
  parameter int START_POS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_btn_n,
  input  logic             btn_up_n,
  input  logic             btn_down_n,
  output logic [LED_W-1:0] led
);

  localparam int NBTN = 3;
  localparam int IDX_DOWN = 0;
  localparam int IDX_UP   = 1;
  localparam int IDX_RST  = 2;

  logic [NBTN-1:0] raw_n;
  logic [NBTN-1:0] synced_n;
  logic [1:0]      falls;
  logic            rst_int;
  logic            down_fall;
  logic            up_fall;

  assign raw_n[IDX_DOWN] = btn_down_n;
  assign raw_n[IDX_UP]   = btn_up_n;
  assign raw_n[IDX_RST]  = rst_btn_n;

  btn_sync #(.W(NBTN), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .async_in (raw_n),
    .sync_out (synced_n)
  );

  assign rst_int = ~synced_n[IDX_RST];

  fall_detect #(.W(2)) u_edge (
    .clk   (clk),
    .level (synced_n[1:0]),
    .fall  (falls)
  );

  assign down_fall = falls[IDX_DOWN];
  assign up_fall   = falls[IDX_UP];

  led_track #(.W(LED_W), .START_POS(START_POS)) u_track (
    .clk      (clk),
    .rst      (rst_int),
    .go_left  (down_fall),
    .go_right (up_fall),
    .led      (led)
  );

endmodule

// File: rtl/led_bar_stepper_chk.sv
module led_bar_stepper_chk #(
  parameter int W         = 8,
  parameter int START_POS = 4
) (
  input logic         clk,
  input logic         rst_sync,
  input logic         go_left,
  input logic         go_right,
  input logic [W-1:0] led
);

  localparam logic [W-1:0] START_PAT = W'(1) << START_POS;

  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (rst_sync) armed <= 1'b1;
  end

  // R1
  a_r1_onehot: assert property (@(posedge clk) disable iff (!armed || rst_sync)
    $onehot(led));

  // R2
  a_r2_start: assert property (@(posedge clk)
    rst_sync |=> (led == START_PAT));

  // R3
  a_r3_left: assert property (@(posedge clk) disable iff (!armed || rst_sync)
    (go_left && !go_right && !led[W-1]) |=> (led == ($past(led) << 1)));

  // R4
  a_r4_right: assert property (@(posedge clk) disable iff (!armed || rst_sync)
    (go_right && !go_left && !led[0]) |=> (led == ($past(led) >> 1)));

  // R5
  a_r5_hold: assert property (@(posedge clk) disable iff (!armed || rst_sync)
    (go_left == go_right) |=> $stable(led));

  // R6
  a_r6_saturate: assert property (@(posedge clk) disable iff (!armed || rst_sync)
    ((go_left && led[W-1]) || (go_right && led[0])) |=> $stable(led));

  // R7
  a_r7_single_left: assert property (@(posedge clk) disable iff (!armed)
    go_left |=> !go_left);

  a_r7_single_right: assert property (@(posedge clk) disable iff (!armed)
    go_right |=> !go_right);

endmodule

bind led_bar_stepper led_bar_stepper_chk #(.W(LED_W), .START_POS(START_POS)) u_chk (
  .clk      (clk),
  .rst_sync (rst_int),
  .go_left  (down_fall),
  .go_right (up_fall),
  .led      (led)
);

// File: tb/led_bar_stepper_test.sv
module led_bar_stepper_test;

  logic       clk = 1'b0;
  logic       rst_btn_n = 1'b0;
  logic       btn_up_n = 1'b1;
  logic       btn_down_n = 1'b1;
  logic [7:0] led;

  int checks = 0;
  int failures = 0;
  logic [7:0] model = 8'h10;
  bit done = 1'b0;

  always #10 clk = ~clk;

  led_bar_stepper uut (
    .clk        (clk),
    .rst_btn_n  (rst_btn_n),
    .btn_up_n   (btn_up_n),
    .btn_down_n (btn_down_n),
    .led        (led)
  );

  function automatic logic [7:0] step(input logic [7:0] cur, input bit up, input bit down);
    if (up == down) return cur;
    if (down) return cur[7] ? cur : (cur << 1);
    return cur[0] ? cur : (cur >> 1);
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (led !== exp) begin
      failures++;
      $display("FAIL %s: led=%h expected=%h", req, led, exp);
    end
    checks++;
    if ($countones(led) != 1) begin
      failures++;
      $display("FAIL R1: led=%h expected one bit set", led);
    end
  endtask

  // Press for 'hold' cycles, release, settle, check.
  task automatic press(input bit up, input bit down, input int hold, input string req);
    @(negedge clk);
    btn_up_n   = ~up;
    btn_down_n = ~down;
    repeat (hold) @(negedge clk);
    btn_up_n   = 1'b1;
    btn_down_n = 1'b1;
    repeat (4) @(negedge clk);
    model = step(model, up, down);
    check(req, model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    check("R2 reset held", 8'h10);
    rst_btn_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 after reset", 8'h10);

    // R8 latency
    @(negedge clk);
    btn_down_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 unchanged after second edge", 8'h10);
    @(negedge clk);
    model = 8'h20;
    check("R8 R3 step at third edge", model);
    // R7 held low
    repeat (20) @(negedge clk);
    check("R7 held down one step", model);
    // R9 release
    btn_down_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 release no step", model);

    press(1'b1, 1'b0, 1, "R4 up step");
    press(1'b1, 1'b1, 2, "R5 both same cycle");
    press(1'b0, 1'b1, 1, "R3 down step");

    // R6 upper end
    for (int i = 0; i < 3; i++) press(1'b0, 1'b1, 2, "R3 walk left");
    check("R6 reached bit 7", 8'h80);
    press(1'b0, 1'b1, 3, "R6 saturate high");
    // R6 lower end
    for (int i = 0; i < 7; i++) press(1'b1, 1'b0, 2, "R4 walk right");
    check("R6 reached bit 0", 8'h01);
    press(1'b1, 1'b0, 3, "R6 saturate low");

    // R7 held up, long
    @(negedge clk);
    btn_up_n = 1'b0;
    repeat (40) @(negedge clk);
    check("R7 held up at end", 8'h01);
    btn_up_n = 1'b1;
    repeat (4) @(negedge clk);

    // Random mix
    for (int i = 0; i < 150; i++) begin
      int sel;
      int hold;
      sel  = $urandom % 3;
      hold = 1 + ($urandom % 5);
      case (sel)
        0: press(1'b1, 1'b0, hold, "R4 random up");
        1: press(1'b0, 1'b1, hold, "R3 random down");
        default: press(1'b1, 1'b1, hold, "R5 random both");
      endcase
    end

    // Mid-run reset, one cycle wide
    press(1'b1, 1'b0, 1, "R4 before reset");
    @(negedge clk);
    rst_btn_n = 1'b0;
    @(negedge clk);
    rst_btn_n = 1'b1;
    repeat (4) @(negedge clk);
    model = 8'h10;
    check("R2 mid-run reset", model);
    press(1'b0, 1'b1, 1, "R3 after reset");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule